// File: doc/BRIEF.md
# Trim Setting Register File with Password Lock

This block is the byte-wide register file that sits behind a two-wire serial target in a trimming device with two digitally set resistors. A serial front end, which is not part of this block, turns bus transactions into single-cycle strobes on a flat internal port. That port has an address, write data, a write strobe, a read strobe and registered read data. The file holds these registers:

- the bus target address byte;
- a configuration byte with two high-impedance controls, one per resistor;
- two 8-bit resistor settings;
- a volatile two-byte password entry;
- a two-byte stored password;
- sixteen bytes of general storage.

Stored values are modelled as flops with reset defaults. Committing them to non-volatile storage is left to another block.

Writes are gated by a two-byte password. The file is unlocked whenever the entered password equals the stored one. While it is locked, only the entry bytes accept writes. Both the entry and the stored password come out of reset at FFFFh, so the file is open until software sets a different password. Each resistor drives an 8-bit setting and a high-impedance flag. Both flags are forced on while reset is held and during a recall window that follows the synchronised release of reset.

Top module: `trim_regmap`

## Requirements
- R1: After reset, reads return A0h at 00h, 00h at 01h, 7Fh at 02h and 03h, and FFh at 10h–1Fh. The stored password at 06h/07h reads FFh/FFh, and both setting outputs are 7Fh.
- R2: A read strobe at a clock edge loads `bus_rdata` at that edge with the byte at `bus_addr`. Without a read strobe, `bus_rdata` holds its value. `bus_rdata` is 00h after reset.
- R3: Addresses 08h–0Fh and 20h upward read 00h. A write to any of them changes no register.
- R4: Only bits 1:0 of the configuration byte at 01h are stored. Bits 7:2 read back as 0, whatever value was written.
- R5: Configuration bit 0 sets `hiz0_o` and bit 1 sets `hiz1_o`. `set0_o` and `set1_o` always carry the values at 02h and 03h, so clearing a bit restores the programmed setting.
- R6: The password entry is 04h (high byte) and 05h (low byte). It accepts writes whether the file is locked or unlocked, always reads 00h, and returns to FFFFh on every reset.
- R7: The file is unlocked exactly when the entry equals the stored password (06h high byte, 07h low byte). While it is locked, writes to any address other than 04h/05h are dropped.
- R8: While the file is locked, 00h–03h and 10h–1Fh still read their contents, and 06h/07h read 00h.
- R9: While the file is unlocked, 06h/07h can be read and written. A change to either byte takes effect in the lock comparison on the very next cycle.
- R10: Both high-impedance flags stay at 1 while `rst_n` is low. They also stay at 1 until RECALL_CYCLES edges after the last of the two reset-synchroniser edges; in total, until edge 2+RECALL_CYCLES after `rst_n` rises.
- R11: When a read and a write hit the same address in the same cycle, the read returns the value held before the write.
- R12: Each of the sixteen general bytes at 10h–1Fh stores its own value independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Registered read data |
| set0_o | output | 8 | Resistor 0 setting |
| hiz0_o | output | 1 | Resistor 0 high-impedance flag |
| set1_o | output | 8 | Resistor 1 setting |
| hiz1_o | output | 1 | Resistor 1 high-impedance flag |

## Verification
The hardest state to reach is a stored password that has only been half rewritten. Writing the high byte of a new password at 06h locks the file at once, so the write of the low byte that follows is silently lost. The stimulus walks straight into this case. It then unlocks with only the matching high entry byte, which confirms that the stored password really became 12FFh. Comparing the outputs on every cycle also covers the recall window after each reset release and a read that collides with a write to the same address.

// File: rtl/trim_regmap_pkg.sv
package trim_regmap_pkg;
  localparam int BYTE_W       = 8;
  localparam int ADR_SLAVE    = 'h00;
  localparam int ADR_CFG      = 'h01;
  localparam int ADR_RES0     = 'h02;
  localparam int ADR_RES1     = 'h03;
  localparam int ADR_KEY_HI   = 'h04;
  localparam int ADR_KEY_LO   = 'h05;
  localparam int ADR_LOCK_HI  = 'h06;
  localparam int ADR_LOCK_LO  = 'h07;
  localparam int CFG_BITS     = 2;

  localparam logic [BYTE_W-1:0] DEF_SLAVE = 8'hA0;
  localparam logic [BYTE_W-1:0] DEF_RES   = 8'h7F;
  localparam logic [BYTE_W-1:0] DEF_USER  = 8'hFF;
  localparam logic [2*BYTE_W-1:0] DEF_PASS = 16'hFFFF;
endpackage

// File: rtl/trim_rst_sync.sv
module trim_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/trim_recall_timer.sv
module trim_recall_timer #(
  parameter int RECALL_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_int_n,
  output logic busy
);
  localparam int CNT_W = $clog2(RECALL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RECALL_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (cnt_q != '0);
    cnt_d  = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cnt_q <= CNT_INIT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  AST_RECALL_MONOTONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |=> !busy); // R10
endmodule

// File: rtl/trim_access_guard.sv
module trim_access_guard
  import trim_regmap_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_int_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BYTE_W-1:0]     bus_wdata,
  input  logic                  bus_wr,
  input  logic [2*BYTE_W-1:0]   stored_pass,
  output logic                  unlocked,
  output logic                  key_hit,
  output logic                  store_we
);
  logic [BYTE_W-1:0] key_hi_q, key_hi_d, key_lo_q, key_lo_d;
  logic              hi_en, lo_en;

  always_comb begin
    hi_en    = bus_wr && (bus_addr == ADDR_W'(ADR_KEY_HI));
    lo_en    = bus_wr && (bus_addr == ADDR_W'(ADR_KEY_LO));
    key_hit  = (bus_addr == ADDR_W'(ADR_KEY_HI)) || (bus_addr == ADDR_W'(ADR_KEY_LO));
    key_hi_d = bus_wdata;
    key_lo_d = bus_wdata;
    unlocked = ({key_hi_q, key_lo_q} == stored_pass);
    store_we = bus_wr && unlocked && !key_hit;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      key_hi_q <= DEF_PASS[2*BYTE_W-1:BYTE_W];
      key_lo_q <= DEF_PASS[BYTE_W-1:0];
    end else begin
      if (hi_en) key_hi_q <= key_hi_d;
      if (lo_en) key_lo_q <= key_lo_d;
    end
  end

  AST_KEY_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == ADDR_W'(ADR_KEY_LO)) |=> (key_lo_q == $past(bus_wdata))); // R6
endmodule

// File: rtl/trim_reg_store.sv
module trim_reg_store
  import trim_regmap_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int USER_BASE  = 16,
  parameter int USER_DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_int_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BYTE_W-1:0]    bus_wdata,
  input  logic                 store_we,
  input  logic                 unlocked,
  output logic [BYTE_W-1:0]    rd_byte,
  output logic [BYTE_W-1:0]    res0,
  output logic [BYTE_W-1:0]    res1,
  output logic [CFG_BITS-1:0]  cfg,
  output logic [2*BYTE_W-1:0]  stored_pass
);
  localparam int USER_IDX_W = $clog2(USER_DEPTH);
  localparam int USER_END   = USER_BASE + USER_DEPTH;

  logic [BYTE_W-1:0]   slave_q, slave_d, res0_q, res0_d, res1_q, res1_d;
  logic [BYTE_W-1:0]   phi_q, phi_d, plo_q, plo_d;
  logic [CFG_BITS-1:0] cfg_q, cfg_d;
  logic                slave_en, cfg_en, res0_en, res1_en, phi_en, plo_en;
  logic [BYTE_W-1:0]   user_q [USER_DEPTH];
  logic                in_user;
  logic [USER_IDX_W-1:0] user_idx;

  always_comb begin
    slave_en = store_we && (bus_addr == ADDR_W'(ADR_SLAVE));
    cfg_en   = store_we && (bus_addr == ADDR_W'(ADR_CFG));
    res0_en  = store_we && (bus_addr == ADDR_W'(ADR_RES0));
    res1_en  = store_we && (bus_addr == ADDR_W'(ADR_RES1));
    phi_en   = store_we && (bus_addr == ADDR_W'(ADR_LOCK_HI));
    plo_en   = store_we && (bus_addr == ADDR_W'(ADR_LOCK_LO));
    slave_d  = bus_wdata;
    cfg_d    = bus_wdata[CFG_BITS-1:0];
    res0_d   = bus_wdata;
    res1_d   = bus_wdata;
    phi_d    = bus_wdata;
    plo_d    = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      slave_q <= DEF_SLAVE;
      cfg_q   <= '0;
      res0_q  <= DEF_RES;
      res1_q  <= DEF_RES;
      phi_q   <= DEF_PASS[2*BYTE_W-1:BYTE_W];
      plo_q   <= DEF_PASS[BYTE_W-1:0];
    end else begin
      if (slave_en) slave_q <= slave_d;
      if (cfg_en)   cfg_q   <= cfg_d;
      if (res0_en)  res0_q  <= res0_d;
      if (res1_en)  res1_q  <= res1_d;
      if (phi_en)   phi_q   <= phi_d;
      if (plo_en)   plo_q   <= plo_d;
    end
  end

  for (genvar gi = 0; gi < USER_DEPTH; gi++) begin : g_user
    logic u_en;
    assign u_en = store_we && (bus_addr == ADDR_W'(USER_BASE + gi));
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) user_q[gi] <= DEF_USER;
      else if (u_en)  user_q[gi] <= bus_wdata;
    end
  end

  always_comb begin
    in_user  = (bus_addr >= ADDR_W'(USER_BASE)) && (bus_addr < ADDR_W'(USER_END));
    user_idx = USER_IDX_W'(bus_addr - ADDR_W'(USER_BASE));
    rd_byte  = '0;
    if (in_user) rd_byte = user_q[user_idx];
    else begin
      case (bus_addr)
        ADDR_W'(ADR_SLAVE):   rd_byte = slave_q;
        ADDR_W'(ADR_CFG):     rd_byte = {{(BYTE_W-CFG_BITS){1'b0}}, cfg_q};
        ADDR_W'(ADR_RES0):    rd_byte = res0_q;
        ADDR_W'(ADR_RES1):    rd_byte = res1_q;
        ADDR_W'(ADR_LOCK_HI): rd_byte = unlocked ? phi_q : '0;
        ADDR_W'(ADR_LOCK_LO): rd_byte = unlocked ? plo_q : '0;
        default:              rd_byte = '0;
      endcase
    end
  end

  assign res0        = res0_q;
  assign res1        = res1_q;
  assign cfg         = cfg_q;
  assign stored_pass = {phi_q, plo_q};

  AST_NO_STORE_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !store_we |=> ($stable(res0_q) && $stable(res1_q) && $stable(phi_q) && $stable(plo_q))); // R7
endmodule

// File: rtl/trim_regmap.sv
module trim_regmap
  import trim_regmap_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int USER_BASE     = 16,
  parameter int USER_DEPTH    = 16,
  parameter int RECALL_CYCLES = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        set0_o,
  output logic              hiz0_o,
  output logic [7:0]        set1_o,
  output logic              hiz1_o
);
  logic                 rst_int_n, recall_busy, unlocked, key_hit, store_we;
  logic [BYTE_W-1:0]    rd_byte, res0, res1, rdata_q, rdata_d;
  logic [CFG_BITS-1:0]  cfg;
  logic [2*BYTE_W-1:0]  stored_pass;

  trim_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n));

  trim_recall_timer #(.RECALL_CYCLES(RECALL_CYCLES)) u_recall (
    .clk(clk), .rst_int_n(rst_int_n), .busy(recall_busy));

  trim_access_guard #(.ADDR_W(ADDR_W)) u_guard (
    .clk(clk), .rst_int_n(rst_int_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .stored_pass(stored_pass), .unlocked(unlocked),
    .key_hit(key_hit), .store_we(store_we));

  trim_reg_store #(.ADDR_W(ADDR_W), .USER_BASE(USER_BASE), .USER_DEPTH(USER_DEPTH)) u_store (
    .clk(clk), .rst_int_n(rst_int_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .store_we(store_we), .unlocked(unlocked), .rd_byte(rd_byte), .res0(res0),
    .res1(res1), .cfg(cfg), .stored_pass(stored_pass));

  always_comb rdata_d = rd_byte;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign set0_o    = res0;
  assign set1_o    = res1;
  assign hiz0_o    = cfg[0] || recall_busy || !rst_int_n;
  assign hiz1_o    = cfg[1] || recall_busy || !rst_int_n;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd |=> $stable(bus_rdata)); // R2
  AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd && bus_addr == ADDR_W'(ADR_CFG)) |=> (bus_rdata[7:CFG_BITS] == '0)); // R4
  AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd && key_hit) |=> (bus_rdata == '0)); // R6
  AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && !unlocked && !key_hit) |=> ($stable(set0_o) && $stable(set1_o))); // R7
  AST_RECALL_HIZ: assert property (@(posedge clk) disable iff (!rst_int_n)
    recall_busy |-> (hiz0_o && hiz1_o)); // R10
endmodule

// File: tb/trim_regmap_bench.sv
module trim_regmap_bench;
  localparam int RECALL = 8;
  localparam int SYNC   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata, set0_o, set1_o;
  logic       hiz0_o, hiz1_o;

  int checks = 0, errors = 0, cycles = 0;
  bit run_cmp = 1'b0;

  trim_regmap #(.RECALL_CYCLES(RECALL), .SYNC_STAGES(SYNC)) u_trim_regmap (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .set0_o(set0_o),
    .hiz0_o(hiz0_o), .set1_o(set1_o), .hiz1_o(hiz1_o));

  always #4 clk = ~clk;

  // behavioural reference
  logic [7:0] m_mem [0:31];
  logic [15:0] m_key;
  logic [7:0]  m_rdata;
  int          m_since;

  function automatic logic m_open();
    return m_key == {m_mem[6], m_mem[7]};
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a == 8'h04 || a == 8'h05) return 8'h00;
    if (a == 8'h06 || a == 8'h07) return m_open() ? m_mem[a[4:0]] : 8'h00;
    if (a <= 8'h03 || (a >= 8'h10 && a <= 8'h1F)) return m_mem[a[4:0]];
    return 8'h00;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 32; i++) m_mem[i] = (i >= 16) ? 8'hFF : 8'h00;
    m_mem[0] = 8'hA0; m_mem[1] = 8'h00; m_mem[2] = 8'h7F; m_mem[3] = 8'h7F;
    m_mem[6] = 8'hFF; m_mem[7] = 8'hFF;
    m_key = 16'hFFFF; m_rdata = 8'h00;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_reset();
      m_since = 0;
    end else begin
      if (m_since >= SYNC) begin
        if (bus_rd) m_rdata = m_read(bus_addr);
        if (bus_wr) begin
          if (bus_addr == 8'h04) m_key[15:8] = bus_wdata;
          else if (bus_addr == 8'h05) m_key[7:0] = bus_wdata;
          else if (m_open()) begin
            if (bus_addr == 8'h01) m_mem[1] = {6'b0, bus_wdata[1:0]};
            else if (bus_addr <= 8'h03 || bus_addr == 8'h06 || bus_addr == 8'h07 ||
                     (bus_addr >= 8'h10 && bus_addr <= 8'h1F))
              m_mem[bus_addr[4:0]] = bus_wdata;
          end
        end
      end
      if (m_since < 1000) m_since++;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp) begin
      logic recall;
      recall = !rst_n || (m_since < SYNC + RECALL);
      chk("R2 rdata", bus_rdata, m_rdata);
      chk("R5 set0", set0_o, m_mem[2]);
      chk("R5 set1", set1_o, m_mem[3]);
      chk("R10 hiz0", {7'b0, hiz0_o}, {7'b0, recall || m_mem[1][0]});
      chk("R10 hiz1", {7'b0, hiz1_o}, {7'b0, recall || m_mem[1][1]});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic do_reset();
    run_cmp = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    run_cmp = 1'b1;
    chk("R10 hiz in reset", {6'b0, hiz1_o, hiz0_o}, 8'h03);
    chk("R2 rdata reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (SYNC + RECALL - 1) @(negedge clk);
    chk("R10 hiz last recall cycle", {6'b0, hiz1_o, hiz0_o}, 8'h03);
    @(negedge clk);
    chk("R10 hiz released", {6'b0, hiz1_o, hiz0_o}, 8'h00);
  endtask

  initial begin
    m_reset(); m_since = 0;
    do_reset();
    chk("R1 set0 default", set0_o, 8'h7F);
    rd("R1 slave", 8'h00, 8'hA0);
    rd("R1 cfg", 8'h01, 8'h00);
    rd("R1 res0", 8'h02, 8'h7F);
    rd("R1 res1", 8'h03, 8'h7F);
    rd("R1 user first", 8'h10, 8'hFF);
    rd("R1 user last", 8'h1F, 8'hFF);
    rd("R1 R9 pass hi", 8'h06, 8'hFF);
    rd("R1 R9 pass lo", 8'h07, 8'hFF);
    // unimplemented
    rd("R3 gap 08", 8'h08, 8'h00);
    rd("R3 gap 0F", 8'h0F, 8'h00);
    rd("R3 above 20", 8'h20, 8'h00);
    wr(8'h08, 8'h55);
    rd("R3 write to gap", 8'h08, 8'h00);
    wr(8'h2A, 8'h11);
    rd("R3 neighbour untouched", 8'h10, 8'hFF);
    // configuration and outputs
    wr(8'h01, 8'hFF);
    rd("R4 cfg upper bits", 8'h01, 8'h03);
    chk("R5 both hiz", {6'b0, hiz1_o, hiz0_o}, 8'h03);
    wr(8'h01, 8'h01);
    chk("R5 hiz0 only", {6'b0, hiz1_o, hiz0_o}, 8'h01);
    wr(8'h01, 8'h02);
    chk("R5 hiz1 only", {6'b0, hiz1_o, hiz0_o}, 8'h02);
    wr(8'h02, 8'h12);
    wr(8'h01, 8'h00);
    chk("R5 restored", {6'b0, hiz1_o, hiz0_o}, 8'h00);
    chk("R5 set0 programmed", set0_o, 8'h12);
    rd("R6 entry reads zero", 8'h04, 8'h00);
    rd("R6 entry lo reads zero", 8'h05, 8'h00);
    // half-written password locks at once
    wr(8'h06, 8'h12);
    wr(8'h07, 8'h34);
    rd("R8 pass hidden", 8'h06, 8'h00);
    rd("R8 pass lo hidden", 8'h07, 8'h00);
    wr(8'h02, 8'hAA);
    chk("R7 locked drop", set0_o, 8'h12);
    rd("R8 res0 readable", 8'h02, 8'h12);
    wr(8'h10, 8'h5A);
    rd("R8 user readable", 8'h10, 8'hFF);
    wr(8'h04, 8'h12);
    rd("R9 pass hi open", 8'h06, 8'h12);
    rd("R9 pass lo kept", 8'h07, 8'hFF);
    wr(8'h02, 8'hAA);
    chk("R7 open write", set0_o, 8'hAA);
    wr(8'h05, 8'h00);
    wr(8'h03, 8'h01);
    chk("R7 relocked drop", set1_o, 8'h7F);
    wr(8'h05, 8'hFF);
    // same cycle read/write
    @(negedge clk); bus_addr = 8'h02; bus_wdata = 8'h33; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R11 old value", bus_rdata, 8'hAA);
    repeat (3) @(negedge clk);
    chk("R2 rdata held", bus_rdata, 8'hAA);
    rd("R11 new value", 8'h02, 8'h33);
    // general storage
    for (int i = 0; i < 16; i++) wr(8'h10 + 8'(i), 8'(i * 7 + 3));
    for (int i = 0; i < 16; i++) rd("R12 user byte", 8'h10 + 8'(i), 8'(i * 7 + 3));
    // reset again: entry and settings return
    wr(8'h04, 8'h00);
    do_reset();
    rd("R6 entry back to open", 8'h06, 8'hFF);
    rd("R1 res0 after reset", 8'h02, 8'h7F);
    wr(8'h03, 8'h44);
    chk("R6 open after reset", set1_o, 8'h44);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule